// File: doc/BRIEF.md
# Serial Multi-Address Display Loader

This block is the serial input stage of a multiplexed display driver. A host shifts a frame into it over three pins: serial data, a serial clock and a strobe. The frame holds column bits first and row-address bits last. When the strobe falls, the block issues a write of the column bits into the display-RAM rows. Every row whose address bit is 1 is written. More than one bit may be set, so several rows receive the same data in one strobe. If the address is all zero, nothing is written; such a strobe only resynchronises chained drivers.

A column-only mode pin selects the frame length:

- **Normal mode:** the frame is 40 bits, with the top `40 - MUX` positions carrying columns and the low `MUX` positions carrying the row address.
- **Column-only mode:** the frame grows to 48 bits, with 40 column bits and 8 address bits whatever the multiplex ratio.

A delayed copy of the serial input leaves on a serial output pin, so drivers can be chained data-out to data-in.

The four pins are asynchronous to the system clock. Each passes through a two-flop synchroniser, and the block detects their edges in the system clock domain. A three-state strobe machine drives the write:

- **`ST_IDLE`** (strobe low): goes to `ST_HOLD` when the synchronised strobe is high.
- **`ST_HOLD`** (strobe high): goes to `ST_COMMIT` on the strobe's falling edge. On that same edge it takes a snapshot of the shift register and the mode.
- **`ST_COMMIT`**: lasts one cycle and drives the write enables and write data from the snapshot. It then returns to `ST_HOLD` if the strobe is already high again, and to `ST_IDLE` otherwise.

Top module: `sdl_loader`

## Requirements
- R1: In normal mode a frame is 40 bits, numbered 40 down to 1 and sent bit 40 first. Bits 1..MUX are row address bits and bits MUX+1..40 are column bits.
- R2: With `col_only_i` high a frame is 48 bits, numbered 48 down to 1 and sent bit 48 first. Bits 1..8 are address bits and bits 9..48 are column bits, independent of MUX.
- R3: The shift register takes in `ser_data_i` only on a falling edge of `ser_clk_i`. Its contents stay unchanged in every other cycle.
- R4: `ser_data_o` changes only after a rising edge of `ser_clk_i`. The value read just before the k-th falling edge equals the bit taken in at falling edge k-40 (normal mode) or k-48 (column-only), and is 0 while fewer bits than that have been taken in since reset.
- R5: After a falling edge of `strobe_i`, `row_we_o[k-1]` is asserted for each address bit k that is 1. The same data goes to every such row. In normal mode bits MUX..7 of `row_we_o` are never set.
- R6: An all-zero address produces no write enable at all.
- R7: Each strobe fall gives exactly one system-clock cycle of write enables. That cycle falls within 12 cycles of the pin's fall.
- R8: During the write cycle, `row_wdata_o[i]` depends on the mode. In normal mode it equals frame bit i+1 for i >= MUX, and 0 for i < MUX. In column-only mode it equals frame bit i+9.
- R9: If a serial-clock fall is detected in the same cycle as the strobe fall, the written word excludes the newly arriving bit. That bit still enters the shift register.
- R10: After reset, `row_we_o` is 0, `ser_data_o` is 0 and the shift register is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial clock: shift on fall, output on rise |
| ser_data_i | input | 1 | Serial data in |
| strobe_i | input | 1 | Strobe; its falling edge commits the frame |
| col_only_i | input | 1 | 1 selects the 48-bit column-only frame |
| ser_data_o | output | 1 | Serial data out for chaining |
| row_we_o | output | ADDR_W (8) | One write enable per display-RAM row |
| row_wdata_o | output | COLS (40) | Column data written to the enabled rows |

## Verification
A shift on a serial-clock fall and the commit on a strobe fall can both be detected in one system cycle. The bench provokes this by dropping both pins in the same instant, so both edges go through identical synchroniser depth. It then checks that the pulse carries the frame as it stood before that bit. Later serial-output checks confirm that the extra bit still entered the register.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_COMMIT
    } strobe_state_e;

    localparam int unsigned PIN_SCLK = 0;
    localparam int unsigned PIN_DATA = 1;
    localparam int unsigned PIN_STR  = 2;
    localparam int unsigned PIN_COL  = 3;
    localparam int unsigned PIN_CNT  = 4;
endpackage

// File: rtl/sdl_pin_sync.sv
module sdl_pin_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_pin
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                chain_q <= '0;
                prev_q  <= 1'b0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pin_i[b]};
                prev_q  <= chain_q[STAGES-1];
            end
        end

        assign level_o[b] = chain_q[STAGES-1];
        assign rise_o[b]  = chain_q[STAGES-1] & ~prev_q;
        assign fall_o[b]  = ~chain_q[STAGES-1] & prev_q;
    end
endmodule

// File: rtl/sdl_shifter.sv
module sdl_shifter #(
    parameter int unsigned NORM_LEN = 40,
    parameter int unsigned WIDE_LEN = 48
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                shift_en_i,
    input  logic                emit_en_i,
    input  logic                bit_i,
    input  logic                wide_i,
    output logic [WIDE_LEN-1:0] word_o,
    output logic                ser_o
);
    logic [WIDE_LEN-1:0] sreg_q;
    logic                ser_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sreg_q <= '0;
            ser_q  <= 1'b0;
        end else begin
            if (shift_en_i) begin
                sreg_q <= {sreg_q[WIDE_LEN-2:0], bit_i};
            end
            if (emit_en_i) begin
                ser_q <= wide_i ? sreg_q[WIDE_LEN-1] : sreg_q[NORM_LEN-1];
            end
        end
    end

    assign word_o = sreg_q;
    assign ser_o  = ser_q;
endmodule

// File: rtl/sdl_strobe_fsm.sv
module sdl_strobe_fsm
    import sdl_pkg::*;
#(
    parameter int unsigned MUX    = 8,
    parameter int unsigned COLS   = 40,
    parameter int unsigned ADDR_W = 8,
    localparam int unsigned WIDE_LEN = COLS + ADDR_W
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                str_level_i,
    input  logic                str_fall_i,
    input  logic                wide_i,
    input  logic [WIDE_LEN-1:0] word_i,
    output logic [ADDR_W-1:0]   we_o,
    output logic [COLS-1:0]     wdata_o,
    output logic                commit_wide_o
);
    strobe_state_e       state_q, state_d;
    logic [WIDE_LEN-1:0] snap_q;
    logic                snap_wide_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (str_level_i) state_d = ST_HOLD;
            ST_HOLD:   if (str_fall_i)  state_d = ST_COMMIT;
            ST_COMMIT: state_d = str_level_i ? ST_HOLD : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            snap_q      <= '0;
            snap_wide_q <= 1'b0;
        end else if (state_q == ST_HOLD && str_fall_i) begin
            snap_q      <= word_i;
            snap_wide_q <= wide_i;
        end
    end

    always_comb begin
        we_o    = '0;
        wdata_o = '0;
        if (state_q == ST_COMMIT) begin
            for (int unsigned r = 0; r < ADDR_W; r++) begin
                we_o[r] = snap_q[r] & (snap_wide_q || (r < MUX));
            end
            for (int unsigned c = 0; c < COLS; c++) begin
                if (snap_wide_q) begin
                    wdata_o[c] = snap_q[c + ADDR_W];
                end else if (c >= MUX) begin
                    wdata_o[c] = snap_q[c];
                end
            end
        end
    end

    assign commit_wide_o = snap_wide_q;
endmodule

// File: rtl/sdl_loader.sv
module sdl_loader
    import sdl_pkg::*;
#(
    parameter int unsigned MUX    = 8,
    parameter int unsigned COLS   = 40,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ser_clk_i,
    input  logic              ser_data_i,
    input  logic              strobe_i,
    input  logic              col_only_i,
    output logic              ser_data_o,
    output logic [ADDR_W-1:0] row_we_o,
    output logic [COLS-1:0]   row_wdata_o
);
    localparam int unsigned NORM_LEN = COLS;
    localparam int unsigned WIDE_LEN = COLS + ADDR_W;

    logic [PIN_CNT-1:0]  pins, pin_lvl, pin_rise, pin_fall;
    logic                sclk_rise, sclk_fall;
    logic [WIDE_LEN-1:0] word;
    logic                wide_commit;

    assign pins[PIN_SCLK] = ser_clk_i;
    assign pins[PIN_DATA] = ser_data_i;
    assign pins[PIN_STR]  = strobe_i;
    assign pins[PIN_COL]  = col_only_i;

    sdl_pin_sync #(.WIDTH(PIN_CNT), .STAGES(2)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (pins),
        .level_o(pin_lvl),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    assign sclk_rise = pin_rise[PIN_SCLK];
    assign sclk_fall = pin_fall[PIN_SCLK];

    sdl_shifter #(.NORM_LEN(NORM_LEN), .WIDE_LEN(WIDE_LEN)) u_shift (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .shift_en_i(sclk_fall),
        .emit_en_i (sclk_rise),
        .bit_i     (pin_lvl[PIN_DATA]),
        .wide_i    (pin_lvl[PIN_COL]),
        .word_o    (word),
        .ser_o     (ser_data_o)
    );

    sdl_strobe_fsm #(.MUX(MUX), .COLS(COLS), .ADDR_W(ADDR_W)) u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .str_level_i  (pin_lvl[PIN_STR]),
        .str_fall_i   (pin_fall[PIN_STR]),
        .wide_i       (pin_lvl[PIN_COL]),
        .word_i       (word),
        .we_o         (row_we_o),
        .wdata_o      (row_wdata_o),
        .commit_wide_o(wide_commit)
    );
endmodule

// File: rtl/sdl_loader_chk.sv
module sdl_loader_chk #(
    parameter int unsigned MUX    = 8,
    parameter int unsigned COLS   = 40,
    parameter int unsigned ADDR_W = 8,
    localparam int unsigned WIDE_LEN = COLS + ADDR_W
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                ser_data_o,
    input logic [ADDR_W-1:0]   row_we_o,
    input logic [COLS-1:0]     row_wdata_o,
    input logic                sclk_rise,
    input logic                sclk_fall,
    input logic [WIDE_LEN-1:0] word,
    input logic                wide_commit
);
    // R7
    we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|row_we_o) |=> (row_we_o == '0));

    // R4
    do_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(ser_data_o) |-> $past(sclk_rise));

    // R3
    shift_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sclk_fall |=> $stable(word));

    // R8
    pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|row_we_o) && !wide_commit) |-> (row_wdata_o[MUX-1:0] == '0));

    // R5
    row_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wide_commit |-> ((row_we_o >> MUX) == '0));
endmodule

bind sdl_loader sdl_loader_chk #(.MUX(MUX), .COLS(COLS), .ADDR_W(ADDR_W)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ser_data_o (ser_data_o),
    .row_we_o   (row_we_o),
    .row_wdata_o(row_wdata_o),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .word       (word),
    .wide_commit(wide_commit)
);

// File: tb/sdl_loader_tb_top.sv
`timescale 1ns/1ps
module sdl_loader_tb_top;
    localparam int MUX = 8;
    localparam int COLS = 40;
    localparam int ADDR_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1;
    logic sdat = 1'b0;
    logic str = 1'b0;
    logic col = 1'b0;
    logic sout;
    logic [ADDR_W-1:0] we;
    logic [COLS-1:0] wd;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic hist [0:8191];
    int idx = 0;

    always #5 clk = ~clk;

    sdl_loader #(.MUX(MUX), .COLS(COLS), .ADDR_W(ADDR_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_data_i(sdat),
        .strobe_i(str), .col_only_i(col), .ser_data_o(sout),
        .row_we_o(we), .row_wdata_o(wd)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int frame_len(input bit wide);
        return wide ? COLS + ADDR_W : COLS;
    endfunction

    function automatic logic [ADDR_W-1:0] exp_we(input logic [47:0] w, input bit wide);
        logic [ADDR_W-1:0] r;
        for (int i = 0; i < ADDR_W; i++) r[i] = w[i] & (wide || i < MUX);
        return r;
    endfunction

    function automatic logic [COLS-1:0] exp_wd(input logic [47:0] w, input bit wide);
        logic [COLS-1:0] r;
        for (int i = 0; i < COLS; i++) r[i] = wide ? w[i + ADDR_W] : (i >= MUX ? w[i] : 1'b0);
        return r;
    endfunction

    // R4: serial output just before each fall equals the bit taken in one frame earlier
    task automatic sample_do();
        logic e;
        int L;
        L = frame_len(col);
        e = (idx >= L) ? hist[idx - L] : 1'b0;
        check(col ? "R4 R2 serial delay 48" : "R4 R1 serial delay 40", {63'b0, sout}, {63'b0, e});
    endtask

    // R3: one bit per falling serial-clock edge
    task automatic send_bit(input logic b);
        sdat = b;
        tick(4);
        sample_do();
        hist[idx] = b;
        idx++;
        sclk = 1'b0;
        tick(8);
        sclk = 1'b1;
        tick(4);
    endtask

    task automatic send_word(input logic [47:0] w);
        for (int k = frame_len(col) - 1; k >= 0; k--) send_bit(w[k]);
    endtask

    task automatic watch_pulse(input string req, input logic [ADDR_W-1:0] ewe,
                               input logic [COLS-1:0] ewd);
        int pulses;
        logic [ADDR_W-1:0] gwe;
        logic [COLS-1:0] gwd;
        pulses = 0;
        gwe = '0;
        gwd = '0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (we != '0) begin
                pulses++;
                gwe = we;
                gwd = wd;
            end
        end
        // R7
        check({req, " R7 pulse count"}, 64'(pulses), (ewe != '0) ? 64'd1 : 64'd0);
        // R5 R6
        check({req, " R5 R6 enables"}, 64'(gwe), 64'(ewe));
        // R8
        if (ewe != '0) check({req, " R8 data"}, 64'(gwd), 64'(ewd));
        tick(1);
    endtask

    task automatic strobe_word(input string req, input logic [47:0] w);
        str = 1'b1;
        tick(6);
        str = 1'b0;
        watch_pulse(req, exp_we(w, col), exp_wd(w, col));
    endtask

    // R9: strobe fall and serial-clock fall in the same instant
    task automatic collide(input logic [47:0] w, input logic b);
        str = 1'b1;
        tick(6);
        sdat = b;
        tick(4);
        sample_do();
        hist[idx] = b;
        idx++;
        sclk = 1'b0;
        str = 1'b0;
        watch_pulse("R9 collision", exp_we(w, col), exp_wd(w, col));
        sclk = 1'b1;
        tick(4);
    endtask

    task automatic do_reset(input bit wide);
        rst_n = 1'b0;
        col = wide;
        sclk = 1'b1;
        str = 1'b0;
        sdat = 1'b0;
        idx = 0;
        tick(3);
        // R10
        check("R10 reset enables", 64'(we), 64'd0);
        check("R10 reset serial out", {63'b0, sout}, 64'd0);
        rst_n = 1'b1;
        tick(6);
    endtask

    task automatic run_phase(input bit wide, input int nrand);
        logic [47:0] w;
        do_reset(wide);
        // multi-row write: all address bits set
        w = {$urandom, $urandom};
        w[7:0] = 8'hFF;
        send_word(w);
        strobe_word(wide ? "R2 R5 all rows" : "R1 R5 all rows", w);
        // R6: zero address, then confirm enables stay low
        w = {$urandom, $urandom};
        w[7:0] = 8'h00;
        if (!wide) w[MUX-1:0] = '0;
        send_word(w);
        strobe_word("R6 zero address", w);
        // single row 1
        w = {$urandom, $urandom};
        w[7:0] = 8'h01;
        send_word(w);
        strobe_word("R5 row1", w);
        for (int i = 0; i < nrand; i++) begin
            w = {$urandom, $urandom};
            send_word(w);
            strobe_word(wide ? "R2 random" : "R1 random", w);
        end
        // R9 collision, then a fresh word to show shifting continues
        w = {$urandom, $urandom};
        w[0] = 1'b1;
        send_word(w);
        collide(w, 1'b1);
        w = {$urandom, $urandom};
        w[1] = 1'b1;
        send_word(w);
        strobe_word("R9 after collision", w);
    endtask

    initial begin
        void'($urandom(32'd24601));
        run_phase(1'b0, 8);
        run_phase(1'b1, 6);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule